// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory of a small distributed shared-memory system. For every memory block it owns, it records a coherence state and a bit vector with one bit per processor that marks which caches hold a copy. Processor caches send it read misses, write misses and write-backs. The controller updates the directory entry, reads and writes its local block memory, and sends point-to-point invalidate, fetch, fetch-and-invalidate and data-reply messages to the processors named in the vector. It never broadcasts.

The controller works on one request at a time. A request is accepted on a valid/ready channel. While the controller works on it, the request channel is held not-ready. Outgoing messages leave on a single valid/ready port. When several invalidates are needed, they go out one per accepted message, starting with the lowest processor number. An owner answers a fetch on a separate response channel. The controller takes the response only while it is waiting for one.

Top module: `coh_home_dir`

## Requirements
- R1: After reset, `req_ready` is 1 and `msg_valid` is 0. Every block is Uncached and its memory word is zero.
- R2: A read miss (`req_kind`=0) to an Uncached block returns a data reply (`msg_kind`=3) to the requester with the memory word. The block becomes Shared, with only the requester in the sharer vector.
- R3: A write miss (`req_kind`=1) to an Uncached block returns a data reply with the memory word. The block becomes Exclusive, with the requester as owner.
- R4: A read miss to a Shared block returns a data reply with the memory word and adds the requester to the sharers. The block stays Shared.
- R5: A write miss to a Shared block sends an invalidate (`msg_kind`=0) to every current sharer, including the requester if it is one, in ascending processor order, one per accepted message. A data reply with the memory word follows. The requester becomes the sole owner in Exclusive.
- R6: A read miss to an Exclusive block sends a fetch (`msg_kind`=1) to the owner and then waits, with `req_ready` 0 and `msg_valid` 0, until `rsp_valid`. The response word is written to memory and sent to the requester in a data reply. The block becomes Shared, with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (`msg_kind`=2) to the owner and waits for the response. The returned word goes to the requester in a data reply. The block stays Exclusive, with the requester as the only owner.
- R8: A write-back (`req_kind`=2) to an Exclusive block writes `req_data` to memory, clears the sharers and makes the block Uncached. It sends no message, and `req_ready` stays 1.
- R9: A write-back to an Uncached or Shared block is ignored. Memory and directory are unchanged and no message is sent.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the message stays valid and `msg_kind`, `msg_dest`, `msg_blk` and `msg_data` hold their values. `msg_blk` carries the block of the request being served.
- R11: After a read or write miss is accepted, `req_ready` stays 0 until the final data reply is accepted. No message is offered while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_proc | input | PROC_W | Requesting processor number |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dest | output | PROC_W | Destination processor |
| msg_blk | output | BLK_W | Block index |
| msg_data | output | DATA_W | Reply data (zero for other kinds) |
| rsp_valid | input | 1 | Owner's fetch response present |
| rsp_data | input | DATA_W | Owner's block data |

## Verification
The bench builds the controller with four processors, eight blocks and 16-bit data. Four processors let a single write miss invalidate up to four sharers in ascending order, including the requester's own copy. Eight blocks are few enough that a pseudo-random request stream returns to the same blocks often and passes each one through every state transition and every ignored write-back. An irregular `msg_ready` pattern stalls invalidates, fetches and replies in the middle of a sequence.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD_MISS    = 2'd0,
    REQ_WR_MISS    = 2'd1,
    REQ_WRITE_BACK = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_INVAL      = 2'd0,
    MSG_FETCH      = 2'd1,
    MSG_FETCH_INV  = 2'd2,
    MSG_DATA_REPLY = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    DIR_UNCACHED = 2'd0,
    DIR_SHARED   = 2'd1,
    DIR_EXCL     = 2'd2
  } dir_state_e;

  typedef enum logic [2:0] {
    CTL_IDLE,
    CTL_INVAL,
    CTL_FETCH,
    CTL_WAIT,
    CTL_REPLY
  } ctl_state_e;
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] idx,
  output dir_state_e       rd_st,
  output logic [NPROC-1:0] rd_shr,
  input  logic             we,
  input  dir_state_e       wr_st,
  input  logic [NPROC-1:0] wr_shr
);
  dir_state_e       st_q  [NBLK];
  logic [NPROC-1:0] shr_q [NBLK];

  assign rd_st  = st_q[idx];
  assign rd_shr = shr_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st_q[b]  <= DIR_UNCACHED;
        shr_q[b] <= '0;
      end
    end else if (we) begin
      st_q[idx]  <= wr_st;
      shr_q[idx] <= wr_shr;
    end
  end
endmodule

// File: rtl/coh_blk_mem.sv
module coh_blk_mem #(
  parameter int NBLK   = 16,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [BLK_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [NBLK];

  assign rd_data = word_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) word_q[b] <= '0;
    end else if (we) begin
      word_q[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/coh_first_set.sv
module coh_first_set #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int PROC_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [PROC_W-1:0] req_proc,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [PROC_W-1:0] msg_dest,
  output logic [BLK_W-1:0]  msg_blk,
  output logic [DATA_W-1:0] msg_data,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  // one-hot vector naming a single processor
  function automatic logic [NPROC-1:0] proc_bit(input logic [PROC_W-1:0] p);
    return NPROC'(1) << p;
  endfunction

  ctl_state_e        ctl_q;
  logic [PROC_W-1:0] req_p_q, owner_q;
  logic [BLK_W-1:0]  blk_q;
  logic              rd_q;
  logic [NPROC-1:0]  pend_q;
  logic [DATA_W-1:0] rep_q;

  dir_state_e        tbl_st, tbl_wst;
  logic [NPROC-1:0]  tbl_shr, tbl_wshr;
  logic              tbl_we;
  logic [DATA_W-1:0] mem_rd, mem_wdata;
  logic [BLK_W-1:0]  mem_waddr;
  logic              mem_we;
  logic [NPROC-1:0]  pick_vec, pend_left;
  logic [PROC_W-1:0] pick_idx;

  // named events, visible to the bound checker
  logic evt_accept, evt_msg_done, evt_fetch_done;
  assign evt_accept     = req_valid && req_ready;
  assign evt_msg_done   = msg_valid && msg_ready;
  assign evt_fetch_done = (ctl_q == CTL_WAIT) && rsp_valid;

  coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK), .BLK_W(BLK_W)) table_i (
    .clk(clk), .rst_n(rst_n), .idx(req_blk),
    .rd_st(tbl_st), .rd_shr(tbl_shr),
    .we(tbl_we), .wr_st(tbl_wst), .wr_shr(tbl_wshr)
  );

  coh_blk_mem #(.NBLK(NBLK), .BLK_W(BLK_W), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(req_blk), .rd_data(mem_rd),
    .we(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
  );

  assign pick_vec = (ctl_q == CTL_INVAL) ? pend_q : tbl_shr;

  coh_first_set #(.N(NPROC), .W(PROC_W)) pick_i (.vec(pick_vec), .idx(pick_idx));

  assign pend_left = pend_q & ~proc_bit(pick_idx);

  // directory entry update, decided at acceptance
  always_comb begin
    tbl_we   = 1'b0;
    tbl_wst  = tbl_st;
    tbl_wshr = tbl_shr;
    if (evt_accept) begin
      case (req_kind)
        REQ_RD_MISS: begin
          tbl_we   = 1'b1;
          tbl_wst  = DIR_SHARED;
          tbl_wshr = (tbl_st == DIR_UNCACHED) ? proc_bit(req_proc)
                                              : (tbl_shr | proc_bit(req_proc));
        end
        REQ_WR_MISS: begin
          tbl_we   = 1'b1;
          tbl_wst  = DIR_EXCL;
          tbl_wshr = proc_bit(req_proc);
        end
        REQ_WRITE_BACK: begin
          if (tbl_st == DIR_EXCL) begin
            tbl_we   = 1'b1;
            tbl_wst  = DIR_UNCACHED;
            tbl_wshr = '0;
          end
        end
        default: ;
      endcase
    end
  end

  // memory: owner write-back at accept, or fetched data for a read miss
  assign mem_we    = (evt_accept && req_kind == REQ_WRITE_BACK && tbl_st == DIR_EXCL)
                   || (evt_fetch_done && rd_q);
  assign mem_waddr = (ctl_q == CTL_WAIT) ? blk_q : req_blk;
  assign mem_wdata = (ctl_q == CTL_WAIT) ? rsp_data : req_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_IDLE;
      req_p_q <= '0;
      owner_q <= '0;
      blk_q   <= '0;
      rd_q    <= 1'b0;
      pend_q  <= '0;
      rep_q   <= '0;
    end else begin
      case (ctl_q)
        CTL_IDLE: begin
          if (evt_accept && (req_kind == REQ_RD_MISS || req_kind == REQ_WR_MISS)) begin
            blk_q   <= req_blk;
            req_p_q <= req_proc;
            rd_q    <= (req_kind == REQ_RD_MISS);
            rep_q   <= mem_rd;
            owner_q <= pick_idx;
            pend_q  <= tbl_shr;
            if (tbl_st == DIR_EXCL)
              ctl_q <= CTL_FETCH;
            else if (req_kind == REQ_WR_MISS && tbl_st == DIR_SHARED)
              ctl_q <= CTL_INVAL;
            else
              ctl_q <= CTL_REPLY;
          end
        end
        CTL_INVAL: begin
          if (evt_msg_done) begin
            pend_q <= pend_left;
            if (pend_left == '0) ctl_q <= CTL_REPLY;
          end
        end
        CTL_FETCH: begin
          if (evt_msg_done) ctl_q <= CTL_WAIT;
        end
        CTL_WAIT: begin
          if (rsp_valid) begin
            rep_q <= rsp_data;
            ctl_q <= CTL_REPLY;
          end
        end
        CTL_REPLY: begin
          if (evt_msg_done) ctl_q <= CTL_IDLE;
        end
        default: ctl_q <= CTL_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (ctl_q == CTL_IDLE);
    msg_valid = 1'b0;
    msg_kind  = MSG_DATA_REPLY;
    msg_dest  = req_p_q;
    msg_data  = '0;
    case (ctl_q)
      CTL_INVAL: begin
        msg_valid = 1'b1;
        msg_kind  = MSG_INVAL;
        msg_dest  = pick_idx;
      end
      CTL_FETCH: begin
        msg_valid = 1'b1;
        msg_kind  = rd_q ? MSG_FETCH : MSG_FETCH_INV;
        msg_dest  = owner_q;
      end
      CTL_REPLY: begin
        msg_valid = 1'b1;
        msg_data  = rep_q;
      end
      default: ;
    endcase
  end
  assign msg_blk = blk_q;
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk
  import coh_dir_pkg::*;
#(
  parameter int PROC_W = 2,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_kind,
  input logic [PROC_W-1:0] msg_dest,
  input logic [BLK_W-1:0]  msg_blk,
  input logic [DATA_W-1:0] msg_data,
  input logic              evt_accept,
  input logic              evt_msg_done
);
  logic              have_last;
  logic [PROC_W-1:0] last_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_dest <= '0;
    end else if (evt_accept) begin
      have_last <= 1'b0;
    end else if (evt_msg_done && msg_kind == MSG_INVAL) begin
      have_last <= 1'b1;
      last_dest <= msg_dest;
    end
  end

  // R10: a stalled message holds its fields
  assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                   && $stable(msg_blk) && $stable(msg_data)));

  // R11: an accepted miss makes the controller busy
  assert_miss_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && req_kind != REQ_WRITE_BACK) |=> !req_ready);

  // R11: no message while requests are accepted
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !msg_valid);

  // R6 R7: after a fetch goes out, nothing until the response
  assert_fetch_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_msg_done && (msg_kind == MSG_FETCH || msg_kind == MSG_FETCH_INV))
      |=> (!msg_valid && !req_ready));

  // R5: invalidates leave in ascending processor order
  assert_inval_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_msg_done && msg_kind == MSG_INVAL && have_last) |-> (msg_dest > last_dest));

  // R8 R9: a write-back never makes the controller busy
  assert_wb_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && req_kind == REQ_WRITE_BACK) |=> (req_ready && !msg_valid));
endmodule

bind coh_home_dir coh_home_dir_chk #(.PROC_W(PROC_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_kind(req_kind),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
  .msg_dest(msg_dest), .msg_blk(msg_blk), .msg_data(msg_data),
  .evt_accept(evt_accept), .evt_msg_done(evt_msg_done)
);

// File: tb/coh_home_dir_tb_top.sv
module coh_home_dir_tb_top;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int BW = 3;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] M_INV = 2'd0, M_FET = 2'd1, M_FINV = 2'd2, M_REP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [PW-1:0] req_proc = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [1:0] msg_kind;
  logic [PW-1:0] msg_dest;
  logic [BW-1:0] msg_blk;
  logic [DW-1:0] msg_data;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  coh_home_dir #(.NPROC(NP), .NBLK(NB), .DATA_W(DW)) dut_i (.*);

  typedef struct packed {
    logic [1:0]    kind;
    logic [PW-1:0] dest;
    logic [BW-1:0] blk;
    logic [DW-1:0] data;
    logic [DW-1:0] rsp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag_over = "";

  // reference model
  int          m_st [NB];  // 0 uncached, 1 shared, 2 exclusive
  logic [NP-1:0] m_sh [NB];
  logic [DW-1:0] m_mem [NB];
  logic [DW-1:0] m_own [NB];

  bit            rsp_pend = 1'b0;
  logic [DW-1:0] rsp_val = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] k, input int d, input int b,
                      input logic [DW-1:0] v, input logic [DW-1:0] r, input string tg);
    exp_t e;
    e.kind = k; e.dest = PW'(d); e.blk = BW'(b); e.data = v; e.rsp = r;
    exp_q.push_back(e);
    tag_q.push_back((tag_over != "") ? tag_over : tg);
  endtask

  function automatic int low_bit(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  // driver: predicts the messages, then offers the request
  task automatic issue(input logic [1:0] k, input int p, input int b, input logic [DW-1:0] d);
    logic [NP-1:0] pb;
    int own;
    pb = NP'(1) << p;
    case (k)
      K_RD: begin
        if (m_st[b] == 2) begin
          own = low_bit(m_sh[b]);
          push(M_FET, own, b, '0, m_own[b], "R6");
          push(M_REP, p, b, m_own[b], '0, "R6");
          m_mem[b] = m_own[b];
          m_sh[b] = m_sh[b] | pb;
        end else begin
          push(M_REP, p, b, m_mem[b], '0, (m_st[b] == 0) ? "R2" : "R4");
          m_sh[b] = (m_st[b] == 0) ? pb : (m_sh[b] | pb);
        end
        m_st[b] = 1;
      end
      K_WR: begin
        if (m_st[b] == 2) begin
          own = low_bit(m_sh[b]);
          push(M_FINV, own, b, '0, m_own[b], "R7");
          push(M_REP, p, b, m_own[b], '0, "R7");
        end else if (m_st[b] == 1) begin
          for (int i = 0; i < NP; i++) if (m_sh[b][i]) push(M_INV, i, b, '0, '0, "R5");
          push(M_REP, p, b, m_mem[b], '0, "R5");
        end else begin
          push(M_REP, p, b, m_mem[b], '0, "R3");
        end
        m_st[b] = 2; m_sh[b] = pb; m_own[b] = d;
      end
      default: begin
        if (m_st[b] == 2) begin
          m_mem[b] = d; m_st[b] = 0; m_sh[b] = '0;
        end
      end
    endcase
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = k; req_proc = PW'(p); req_blk = BW'(b); req_data = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    if (k == K_WB)
      chk(req_ready && !msg_valid, "R8", "write-back leaves controller idle",
          {req_ready, msg_valid}, 2'b10);
    else
      chk(!req_ready, "R11", "busy after accepted miss", req_ready, 0);
    while (!(exp_q.size() == 0 && req_ready)) @(negedge clk);
    tag_over = "";
  endtask

  // monitor: pops expected messages at each handshake
  exp_t held;
  bit   held_v = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (held_v) begin
        chk(msg_valid && {msg_kind, msg_dest, msg_blk, msg_data} == {held.kind, held.dest, held.blk, held.data},
            "R10", "stalled message held", {msg_valid, msg_kind, msg_dest, msg_blk, msg_data},
            {1'b1, held.kind, held.dest, held.blk, held.data});
        held_v = 1'b0;
      end
      if (rsp_valid)
        chk(!req_ready && !msg_valid, "R6", "idle while waiting for owner",
            {req_ready, msg_valid}, 2'b00);
      if (msg_valid && !msg_ready) begin
        held.kind = msg_kind; held.dest = msg_dest; held.blk = msg_blk; held.data = msg_data;
        held_v = 1'b1;
      end
      if (msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected message", {msg_kind, msg_dest, msg_blk}, 0);
        end else begin
          exp_t e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(msg_kind == e.kind, tg, "msg kind", msg_kind, e.kind);
          chk(msg_dest == e.dest && msg_blk == e.blk, tg, "msg dest/blk",
              {msg_dest, msg_blk}, {e.dest, e.blk});
          if (e.kind == M_REP) chk(msg_data == e.data, tg, "reply data", msg_data, e.data);
          if (e.kind == M_FET || e.kind == M_FINV) begin
            rsp_pend = 1'b1; rsp_val = e.rsp;
          end
        end
      end
    end
  end

  // owner responder
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rsp_pend) begin
        rsp_valid = 1'b1; rsp_data = rsp_val; rsp_pend = 1'b0;
      end else begin
        rsp_valid = 1'b0; rsp_data = 16'hdead;
      end
    end
  end

  // irregular ready pattern
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #2;
      c++;
      msg_ready = (c % 3 != 0) && (c % 7 != 2);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int b = 0; b < NB; b++) begin
      m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; m_own[b] = '0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !msg_valid, "R1", "reset port state", {req_ready, msg_valid}, 2'b10);

    tag_over = "R1"; issue(K_RD, 0, 0, '0);        // memory zero after reset
    issue(K_RD, 2, 0, '0);                          // R4
    issue(K_RD, 3, 0, '0);                          // R4
    issue(K_WR, 1, 0, 16'h00a1);                    // R5: inval 0,2,3
    issue(K_RD, 2, 0, '0);                          // R6: fetch from 1
    issue(K_WR, 3, 0, 16'h00b2);                    // R5: inval 1,2
    issue(K_WR, 0, 0, 16'h00c3);                    // R7: fetch/inv to 3
    issue(K_WB, 0, 0, 16'h0d0d);                    // R8
    tag_over = "R8"; issue(K_RD, 1, 0, '0);         // memory holds write-back
    issue(K_WB, 2, 0, 16'h0e0e);                    // R9: shared, ignored
    tag_over = "R9"; issue(K_WR, 2, 0, 16'h0f0f);   // inval 1, old data
    issue(K_WB, 1, 5, 16'h1111);                    // R9: uncached, ignored
    tag_over = "R9"; issue(K_RD, 1, 5, '0);
    issue(K_WR, 2, 7, 16'h2222);                    // R3
    issue(K_RD, 2, 7, '0);                          // R6: owner re-reads
    for (int p = 0; p < NP; p++) issue(K_RD, p, 3, '0);
    issue(K_WR, 0, 3, 16'h3333);                    // R5: all four invalidated

    lf = 16'hace1;
    for (int n = 0; n < 120; n++) begin
      logic [1:0] k;
      int p, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      k = (lf[1:0] == 2'd3) ? K_RD : lf[1:0];
      b = int'(lf[4:2]);
      p = int'(lf[6:5]);
      if (k == K_WB && m_st[b] == 2 && lf[7]) p = low_bit(m_sh[b]);
      issue(k, p, b, lf ^ 16'h5a5a);
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "all expected messages seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule